// File: doc/BRIEF.md
# SDRAM Mode Register Loader

This block sits inside a memory controller and owns the loading of the SDRAM mode register. A requester presents a 13-bit value with a one-cycle request strobe. The block checks that the burst-length and CAS-latency codes in the value are usable. A value with a reserved code is refused. A usable value is stored and driven onto the command and address bus as a mode register set command. The command goes out only once every bank is idle and no read or write burst is in flight.

After the command the block holds its ready flag low for a fixed number of clocks, which covers the mandatory gap before the next command. It keeps a shadow copy of the programmed value and presents it as decoded fields. Address bit 8 is a self-clearing bit: its shadow copy shows the written value for one cycle and then returns to 0.

The controller is a four-state machine:
- **ST_READY** is the state the block accepts requests in.
- **ST_HOLD** waits for the banks and burst path to become free.
- **ST_ISSUE** drives the command for one cycle.
- **ST_WAIT** counts the post-load gap.

The transitions are:
- READY→READY when a request is refused.
- READY→ISSUE for a usable request while the block is free.
- READY→HOLD for a usable request while banks are busy or a burst is active.
- HOLD→ISSUE on the first free cycle.
- ISSUE→WAIT always.
- WAIT→READY when the gap timer expires.

Top module: `mrs_ctrl`

## Requirements
- R1: Out of reset, ready_o is 1, mrs_cmd_o, reject_o and held_o are 0, and all shadow fields read 0.
- R2: A usable request sampled while ready_o is 1, with banks_idle_i=1 and burst_active_i=0, makes mrs_cmd_o high for exactly one cycle, in the cycle after the sampling edge. During that cycle addr_o equals the requested value and ba_o equals 2'b00.
- R3: mrs_cmd_o is high only when, in the cycle before, banks_idle_i was 1 and burst_active_i was 0.
- R4: A usable request sampled while banks_idle_i=0 or burst_active_i=1 is not dropped. held_o pulses for one cycle after the sampling edge and no command issues while the block is busy. The command with the original value issues in the cycle after the first free cycle.
- R5: ready_o is 0 from the command cycle until WAIT_CYC (default 2) cycles after it. It returns to 1 in the following cycle. req_valid_i is ignored whenever ready_o is 0.
- R6: In the cycle after the command, the shadow fields reflect the loaded value: burst_len_o = bits 2:0, burst_type_o = bit 3, cas_lat_o = bits 6:4, op_mode_o = bits 12:7.
- R7: Bit 8, shown as op_mode_o[1], reads its written value for one cycle and reads 0 from the next cycle on. All other shadow bits keep their values.
- R8: A request is refused when its burst-length code is not 001, 010 or 011, or its CAS-latency code is not 010, 011 or 110. A refused request makes reject_o pulse in the cycle after the sampling edge and issues no command. It leaves the shadow fields unchanged and keeps ready_o at 1.
- R9: The shadow fields hold their values until the next command, apart from the clearing of bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Load request strobe |
| req_value_i | input | 13 | Requested mode register value |
| banks_idle_i | input | 1 | All banks are idle |
| burst_active_i | input | 1 | A read or write burst is in progress |
| mrs_cmd_o | output | 1 | Mode register set command strobe |
| ba_o | output | 2 | Bank address for the command |
| addr_o | output | 13 | Address bus for the command (0 otherwise) |
| ready_o | output | 1 | Block can accept a request |
| reject_o | output | 1 | Pulse: request refused for a reserved code |
| held_o | output | 1 | Pulse: request held off while busy |
| burst_len_o | output | 3 | Shadow burst-length code |
| burst_type_o | output | 1 | Shadow burst type |
| cas_lat_o | output | 3 | Shadow CAS-latency code |
| op_mode_o | output | 6 | Shadow operating-mode bits 12:7 |

## Verification
The bench goes after the self-clearing bit. A shadow that never clears bit 8, or that clears its neighbours in op_mode_o along with it, shows up one cycle after the load. Requests are blocked first by busy banks and then by an active burst alone. A design that lets either condition through, or that loses the held value, issues early or issues the wrong address.

Reserved burst-length and CAS-latency codes are sent between good loads. A design that refuses nothing overwrites the shadow or emits an unexpected command. A request is also held high during the wait gap. A design that ignores ready_o then issues a second command, and a wrong gap length moves the cycle in which ready_o returns.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
    localparam int MR_W     = 13;
    localparam int BL_LSB   = 0;
    localparam int BL_W     = 3;
    localparam int BT_BIT   = 3;
    localparam int CL_LSB   = 4;
    localparam int CL_W     = 3;
    localparam int OP_LSB   = 7;
    localparam int OP_W     = 6;
    localparam int CLR_BIT  = 8;

    typedef enum logic [1:0] {
        ST_READY,
        ST_HOLD,
        ST_ISSUE,
        ST_WAIT
    } mrs_state_e;

    function automatic logic bl_code_ok(input logic [BL_W-1:0] code);
        return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
    endfunction

    function automatic logic cl_code_ok(input logic [CL_W-1:0] code);
        return (code == 3'b010) || (code == 3'b011) || (code == 3'b110);
    endfunction
endpackage

// File: rtl/mrs_field_check.sv
module mrs_field_check
    import mrs_pkg::*;
(
    input  logic [MR_W-1:0] value_i,
    output logic            legal_o
);
    logic bl_ok;
    logic cl_ok;

    always_comb begin
        bl_ok   = bl_code_ok(value_i[BL_LSB +: BL_W]);
        cl_ok   = cl_code_ok(value_i[CL_LSB +: CL_W]);
        legal_o = bl_ok && cl_ok;
    end
endmodule

// File: rtl/mrs_wait_timer.sv
module mrs_wait_timer #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
    import mrs_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic [MR_W-1:0] req_value_i,
    input  logic            banks_idle_i,
    input  logic            burst_active_i,
    output logic            mrs_cmd_o,
    output logic [1:0]      ba_o,
    output logic [MR_W-1:0] addr_o,
    output logic            ready_o,
    output logic            reject_o,
    output logic            held_o,
    output logic [BL_W-1:0] burst_len_o,
    output logic            burst_type_o,
    output logic [CL_W-1:0] cas_lat_o,
    output logic [OP_W-1:0] op_mode_o
);
    mrs_state_e      state_q, state_d;
    logic [MR_W-1:0] pend_q;
    logic [MR_W-1:0] shadow_q;
    logic            reject_q, held_q;
    logic            req_legal;
    logic            path_free;
    logic            take_req;
    logic            tmr_done;

    mrs_field_check u_check (
        .value_i (req_value_i),
        .legal_o (req_legal)
    );

    mrs_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (state_q == ST_ISSUE),
        .done_o  (tmr_done)
    );

    assign path_free = banks_idle_i && !burst_active_i;
    assign take_req  = (state_q == ST_READY) && req_valid_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (take_req && req_legal) state_d = path_free ? ST_ISSUE : ST_HOLD;
            ST_HOLD:  if (path_free) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (tmr_done) state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    // state and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_READY;
            pend_q   <= '0;
            shadow_q <= '0;
            reject_q <= 1'b0;
            held_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            reject_q <= take_req && !req_legal;
            held_q   <= take_req && req_legal && !path_free;
            if (take_req && req_legal) begin
                pend_q <= req_value_i;
            end
            if (state_q == ST_ISSUE) begin
                shadow_q <= pend_q;
            end else begin
                shadow_q[CLR_BIT] <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        mrs_cmd_o    = (state_q == ST_ISSUE);
        ba_o         = 2'b00;
        addr_o       = (state_q == ST_ISSUE) ? pend_q : '0;
        ready_o      = (state_q == ST_READY);
        reject_o     = reject_q;
        held_o       = held_q;
        burst_len_o  = shadow_q[BL_LSB +: BL_W];
        burst_type_o = shadow_q[BT_BIT];
        cas_lat_o    = shadow_q[CL_LSB +: CL_W];
        op_mode_o    = shadow_q[OP_LSB +: OP_W];
    end

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_cmd_o |-> $past(banks_idle_i && !burst_active_i)); // R3
    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_cmd_o |=> !mrs_cmd_o); // R2
    AST_GAP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_cmd_o |=> !ready_o); // R5
    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_cmd_o |=> {op_mode_o, cas_lat_o, burst_type_o, burst_len_o} == $past(addr_o)); // R6
    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_mode_o[1]) |=> !op_mode_o[1]); // R7
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> !mrs_cmd_o && ready_o && $stable(burst_len_o) && $stable(cas_lat_o)); // R8
    AST_HELD_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        held_o |-> !mrs_cmd_o && !ready_o); // R4
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs_cmd_o |=> $stable(burst_len_o) && $stable(cas_lat_o) && $stable(burst_type_o)); // R9
endmodule

// File: tb/mrs_ctrl_tb.sv
module mrs_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [12:0] req_value_i = '0;
    logic        banks_idle_i = 1'b1;
    logic        burst_active_i = 1'b0;
    logic        mrs_cmd_o;
    logic [1:0]  ba_o;
    logic [12:0] addr_o;
    logic        ready_o, reject_o, held_o;
    logic [2:0]  burst_len_o;
    logic        burst_type_o;
    logic [2:0]  cas_lat_o;
    logic [5:0]  op_mode_o;

    int compared = 0;
    int mismatched = 0;
    logic [12:0] exp_q[$];
    logic prev_free = 1'b1;

    always #5 clk = ~clk;

    mrs_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_value_i(req_value_i),
        .banks_idle_i(banks_idle_i), .burst_active_i(burst_active_i),
        .mrs_cmd_o(mrs_cmd_o), .ba_o(ba_o), .addr_o(addr_o), .ready_o(ready_o),
        .reject_o(reject_o), .held_o(held_o), .burst_len_o(burst_len_o),
        .burst_type_o(burst_type_o), .cas_lat_o(cas_lat_o), .op_mode_o(op_mode_o)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic request(input logic [12:0] v, input bit will_issue);
        req_valid_i = 1'b1;
        req_value_i = v;
        if (will_issue) exp_q.push_back(v);
        tick();
        req_valid_i = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 20 && !ready_o; i++) tick();
        check("R5 ready returns", ready_o, 1);
    endtask

    task automatic check_fields(input string req, input int bl, input int bt, input int cl, input int op);
        check({req, " burst_len"}, burst_len_o, bl);
        check({req, " burst_type"}, burst_type_o, bt);
        check({req, " cas_lat"}, cas_lat_o, cl);
        check({req, " op_mode"}, op_mode_o, op);
    endtask

    // monitor: pops expected commands (R2, R3)
    always @(negedge clk) begin
        if (rst_n && mrs_cmd_o) begin
            if (exp_q.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL R2 unexpected command: actual %0h expected none", addr_o);
            end else begin
                check("R2 command address", addr_o, exp_q.pop_front());
                check("R2 bank address", ba_o, 0);
                check("R3 path free before command", prev_free, 1);
            end
        end
        prev_free = banks_idle_i && !burst_active_i;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 ready", ready_o, 1);
        check("R1 cmd", mrs_cmd_o, 0);
        check("R1 reject", reject_o, 0);
        check("R1 held", held_o, 0);
        check_fields("R1", 0, 0, 0, 0);

        // A: free path, bit 8 set
        request(13'h13A, 1);
        check("R5 not ready in command cycle", ready_o, 0);
        req_valid_i = 1'b1;  // ignored during gap
        req_value_i = 13'h023;
        tick();
        check_fields("R6 load A", 2, 1, 3, 2);
        tick();
        check_fields("R7 bit8 cleared A", 2, 1, 3, 0);
        check("R5 still waiting", ready_o, 0);
        req_valid_i = 1'b0;
        tick();
        check("R5 ready after gap", ready_o, 1);

        // B: held by busy banks, then by burst alone
        banks_idle_i = 1'b0;
        request(13'h023, 1);
        check("R4 held pulse", held_o, 1);
        check("R4 not ready while held", ready_o, 0);
        tick();
        check("R4 held single pulse", held_o, 0);
        repeat (3) tick();
        banks_idle_i = 1'b1;
        burst_active_i = 1'b1;
        repeat (2) tick();
        check_fields("R9 unchanged while held", 2, 1, 3, 0);
        burst_active_i = 1'b0;
        tick();
        tick();
        check_fields("R6 load B", 3, 0, 2, 0);
        wait_ready();

        // C: reserved codes
        request(13'h030, 0);
        check("R8 reject bad burst length", reject_o, 1);
        check("R8 ready kept", ready_o, 1);
        tick();
        check_fields("R8 shadow unchanged", 3, 0, 2, 0);
        request(13'h053, 0);
        check("R8 reject bad CAS latency", reject_o, 1);
        tick();
        check_fields("R9 shadow unchanged", 3, 0, 2, 0);
        request(13'h061, 1);
        tick();
        check_fields("R6 load C", 1, 0, 6, 0);
        wait_ready();

        // D: burst active, other op bits set with bit 8
        burst_active_i = 1'b1;
        request(13'h11AB, 1);
        check("R4 held by burst", held_o, 1);
        tick();
        burst_active_i = 1'b0;
        tick();
        tick();
        check_fields("R6 load D", 3, 1, 2, 6'h23);
        tick();
        check_fields("R7 only bit8 cleared", 3, 1, 2, 6'h21);
        wait_ready();

        repeat (4) tick();
        check("R2 all expected commands seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule